// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 or DDR3L memory interface. It takes the attached memory from power-on to a state where normal traffic may begin. It steps through a fixed series of phases: memory reset asserted, reset released with clock enable held low, clock enable raised, four mode-register writes, and one long impedance calibration. It ends with a settling window in which the device locks its DLL and finishes impedance calibration. Only then does it raise `init_done`.

Every wait is a parameter counted in clock cycles, so a simulation can use short values and silicon can use the real microsecond figures. The mode-register contents come in as ports. A supply-good input that is synchronous to the clock restarts the whole sequence whenever it is sampled low.

After `init_done`, the command bus idles with NOP and the termination-enable output follows a request input. Taking over the bus for normal traffic is left to surrounding logic.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after any edge at which `supply_ok` is sampled low, the outputs are: `ddr_reset_n`=0, `ddr_cke`=0, `ddr_odt`=0, `init_done`=0, and a deselect on the bus. The timeline of R2–R6 restarts from that edge.
- R2: `ddr_reset_n` goes high at the T_RST-th consecutive rising edge at which `supply_ok` is sampled high.
- R3: `ddr_cke` is never high while `ddr_reset_n` is low. It rises exactly T_CKE cycles after `ddr_reset_n` rises.
- R4: Mode-register writes are one-cycle MRS commands, encoded as {cs_n,ras_n,cas_n,we_n}=0000. Bank address selects the register and `ddr_addr` carries its contents. The order is register 2, then 3, then 1, then 0. The register-2 write comes T_XPR cycles after `ddr_cke` rises, and each later write comes T_MRD cycles after the one before it.
- R5: A long calibration command comes T_MOD cycles after the register-0 write. It is encoded as {cs_n,ras_n,cas_n,we_n}=0110, with `ddr_addr` bit 10 set, all other address bits 0, and bank 0.
- R6: `init_done` rises max(T_DLLK,T_ZQI) cycles after the calibration command. It stays high until R1 applies.
- R7: While `ddr_cke` is low the bus carries deselect (all four controls 1, bank and address 0). While `ddr_cke` is high and R4/R5 issue nothing, the bus carries NOP (0111, bank and address 0). No other code ever appears.
- R8: `ddr_odt` is 0 until `init_done` is high. After that it equals `odt_req` as sampled at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supplies stable, synchronous to clk |
| odt_req | input | 1 | Termination request, honoured after init |
| mr0_val | input | ADDR_W | Contents for mode register 0 |
| mr1_val | input | ADDR_W | Contents for mode register 1 |
| mr2_val | input | ADDR_W | Contents for mode register 2 |
| mr3_val | input | ADDR_W | Contents for mode register 3 |
| ddr_reset_n | output | 1 | Memory reset, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_odt | output | 1 | On-die termination enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |

## Verification
Every output is a register loaded from the next phase. A phase that lasts D cycles therefore shows its outputs for exactly D clock edges, and the next phase appears on the edge where the count runs out. The one exception is `ddr_odt`, which mirrors the `odt_req` value sampled at the same edge. The bench marks the last edge at which `supply_ok` or `rst_n` was low, computes each phase boundary by adding the parameter sums to that mark, and compares every output on the falling edge of every cycle. A supply drop is swept across every cycle offset of the sequence, so the restart in R1 is checked from each phase.

// File: rtl/ddr3_bringup_pkg.sv
package ddr3_bringup_pkg;

  typedef enum logic [3:0] {
    PH_RST,
    PH_RSTREL,
    PH_XPR,
    PH_MR2,
    PH_MR3,
    PH_MR1,
    PH_MR0,
    PH_ZQ,
    PH_DONE
  } phase_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } bus_cmd_t;

  localparam bus_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam bus_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam bus_cmd_t CMD_MRS   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam bus_cmd_t CMD_ZQCL  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

  localparam int ZQ_LONG_BIT = 10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load) begin
      cnt_n = load_val;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import ddr3_bringup_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_RST = 4,
  parameter int T_CKE = 4,
  parameter int T_XPR = 4,
  parameter int T_MRD = 4,
  parameter int T_MOD = 4,
  parameter int T_FIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             cnt_zero,
  output phase_t           phase_q,
  output phase_t           phase_n,
  output logic             enter,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  // next phase
  always_comb begin
    phase_n = phase_q;
    if (!supply_ok) begin
      phase_n = PH_RST;
    end else if (cnt_zero) begin
      case (phase_q)
        PH_RST:    phase_n = PH_RSTREL;
        PH_RSTREL: phase_n = PH_XPR;
        PH_XPR:    phase_n = PH_MR2;
        PH_MR2:    phase_n = PH_MR3;
        PH_MR3:    phase_n = PH_MR1;
        PH_MR1:    phase_n = PH_MR0;
        PH_MR0:    phase_n = PH_ZQ;
        PH_ZQ:     phase_n = PH_DONE;
        default:   phase_n = PH_DONE;
      endcase
    end
  end

  // length of the phase being entered, minus one
  always_comb begin
    case (phase_n)
      PH_RST:                   load_val = CNT_W'(T_RST - 1);
      PH_RSTREL:                load_val = CNT_W'(T_CKE - 1);
      PH_XPR:                   load_val = CNT_W'(T_XPR - 1);
      PH_MR2, PH_MR3, PH_MR1:   load_val = CNT_W'(T_MRD - 1);
      PH_MR0:                   load_val = CNT_W'(T_MOD - 1);
      PH_ZQ:                    load_val = CNT_W'(T_FIN - 1);
      default:                  load_val = '0;
    endcase
  end

  assign enter = (phase_n != phase_q);
  assign load  = enter || !supply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RST;
    end else begin
      phase_q <= phase_n;
    end
  end

  // R4: register 2 write is followed by register 3 once its wait ends
  a_r4_mr2_then_mr3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MR2 && cnt_zero && supply_ok) |=> (phase_q == PH_MR3));

  // R5: calibration follows the register 0 write once its wait ends
  a_r5_zq_after_mr0: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MR0 && cnt_zero && supply_ok) |=> (phase_q == PH_ZQ));

  // R6: completion holds while supplies stay good
  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE && supply_ok) |=> (phase_q == PH_DONE));

endmodule

// File: rtl/bringup_bus_drv.sv
module bringup_bus_drv
  import ddr3_bringup_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase_n,
  input  logic              enter,
  input  logic              odt_req,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] mr1_val,
  input  logic [ADDR_W-1:0] mr2_val,
  input  logic [ADDR_W-1:0] mr3_val,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  bus_cmd_t          cmd_n;
  logic [BA_W-1:0]   ba_n;
  logic [ADDR_W-1:0] addr_n;
  logic              rstn_n;
  logic              cke_n;
  logic              done_n;

  always_comb begin
    rstn_n = (phase_n != PH_RST);
    cke_n  = (phase_n != PH_RST) && (phase_n != PH_RSTREL);
    done_n = (phase_n == PH_DONE);
    cmd_n  = cke_n ? CMD_NOP : CMD_DESEL;
    ba_n   = '0;
    addr_n = '0;
    if (enter) begin
      case (phase_n)
        PH_MR2: begin cmd_n = CMD_MRS; ba_n = BA_W'(2); addr_n = mr2_val; end
        PH_MR3: begin cmd_n = CMD_MRS; ba_n = BA_W'(3); addr_n = mr3_val; end
        PH_MR1: begin cmd_n = CMD_MRS; ba_n = BA_W'(1); addr_n = mr1_val; end
        PH_MR0: begin cmd_n = CMD_MRS; ba_n = BA_W'(0); addr_n = mr0_val; end
        PH_ZQ:  begin cmd_n = CMD_ZQCL; addr_n[ZQ_LONG_BIT] = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_reset_n <= 1'b0;
      ddr_cke     <= 1'b0;
      ddr_odt     <= 1'b0;
      ddr_cs_n    <= 1'b1;
      ddr_ras_n   <= 1'b1;
      ddr_cas_n   <= 1'b1;
      ddr_we_n    <= 1'b1;
      ddr_ba      <= '0;
      ddr_addr    <= '0;
      init_done   <= 1'b0;
    end else begin
      ddr_reset_n <= rstn_n;
      ddr_cke     <= cke_n;
      ddr_odt     <= done_n && odt_req;
      ddr_cs_n    <= cmd_n.cs_n;
      ddr_ras_n   <= cmd_n.ras_n;
      ddr_cas_n   <= cmd_n.cas_n;
      ddr_we_n    <= cmd_n.we_n;
      ddr_ba      <= ba_n;
      ddr_addr    <= addr_n;
      init_done   <= done_n;
    end
  end

  // R3: clock enable never leads the reset release
  a_r3_cke_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |-> ddr_reset_n);

  // R7: only NOP, MRS or long calibration when selected
  a_r7_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cs_n |-> ({ddr_ras_n, ddr_cas_n, ddr_we_n} inside {3'b111, 3'b000, 3'b110}));

  // R7: deselect while clock enable is low
  a_r7_deselect_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cke |-> ddr_cs_n);

  // R8: termination stays off before completion
  a_r8_odt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ddr_odt);

endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq
  import ddr3_bringup_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BA_W   = 3,
  parameter int T_RST  = 160000,
  parameter int T_CKE  = 400000,
  parameter int T_XPR  = 288,
  parameter int T_MRD  = 4,
  parameter int T_MOD  = 12,
  parameter int T_DLLK = 512,
  parameter int T_ZQI  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              odt_req,
  input  logic [ADDR_W-1:0] mr0_val,
  input  logic [ADDR_W-1:0] mr1_val,
  input  logic [ADDR_W-1:0] mr2_val,
  input  logic [ADDR_W-1:0] mr3_val,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);

  localparam int T_FIN    = imax(T_DLLK, T_ZQI);
  localparam int MAX_WAIT = imax(imax(imax(T_RST, T_CKE), imax(T_XPR, T_MRD)),
                                 imax(T_MOD, T_FIN));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  phase_t           phase_q;
  phase_t           phase_n;
  logic             enter;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;

  bringup_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (T_RST - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (cnt_zero)
  );

  bringup_fsm #(
    .CNT_W (CNT_W),
    .T_RST (T_RST),
    .T_CKE (T_CKE),
    .T_XPR (T_XPR),
    .T_MRD (T_MRD),
    .T_MOD (T_MOD),
    .T_FIN (T_FIN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cnt_zero  (cnt_zero),
    .phase_q   (phase_q),
    .phase_n   (phase_n),
    .enter     (enter),
    .load      (load),
    .load_val  (load_val)
  );

  bringup_bus_drv #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
  ) u_drv (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_n     (phase_n),
    .enter       (enter),
    .odt_req     (odt_req),
    .mr0_val     (mr0_val),
    .mr1_val     (mr1_val),
    .mr2_val     (mr2_val),
    .mr3_val     (mr3_val),
    .ddr_reset_n (ddr_reset_n),
    .ddr_cke     (ddr_cke),
    .ddr_odt     (ddr_odt),
    .ddr_cs_n    (ddr_cs_n),
    .ddr_ras_n   (ddr_ras_n),
    .ddr_cas_n   (ddr_cas_n),
    .ddr_we_n    (ddr_we_n),
    .ddr_ba      (ddr_ba),
    .ddr_addr    (ddr_addr),
    .init_done   (init_done)
  );

  // R1: a low supply sample returns the pins to their reset levels
  a_r1_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!ddr_reset_n && !ddr_cke && !init_done && ddr_cs_n));

endmodule

// File: tb/ddr3_bringup_seq_test.sv
`timescale 1ns/1ps
module ddr3_bringup_seq_test;

  localparam int AW     = 15;
  localparam int BW     = 3;
  localparam int P_RST  = 6;
  localparam int P_CKE  = 9;
  localparam int P_XPR  = 5;
  localparam int P_MRD  = 4;
  localparam int P_MOD  = 7;
  localparam int P_DLLK = 20;
  localparam int P_ZQI  = 13;
  localparam int P_FIN  = (P_DLLK > P_ZQI) ? P_DLLK : P_ZQI;

  localparam int E_CKE = P_RST + P_CKE;
  localparam int E_MR2 = E_CKE + P_XPR;
  localparam int E_MR3 = E_MR2 + P_MRD;
  localparam int E_MR1 = E_MR3 + P_MRD;
  localparam int E_MR0 = E_MR1 + P_MRD;
  localparam int E_ZQ  = E_MR0 + P_MOD;
  localparam int E_DON = E_ZQ + P_FIN;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_ok;
  logic          odt_req;
  logic [AW-1:0] mr0_val, mr1_val, mr2_val, mr3_val;
  logic          ddr_reset_n, ddr_cke, ddr_odt;
  logic          ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [BW-1:0] ddr_ba;
  logic [AW-1:0] ddr_addr;
  logic          init_done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int s_mark = 0;
  logic odt_s = 1'b0;

  always #2.5 clk = ~clk;

  ddr3_bringup_seq #(
    .ADDR_W (AW), .BA_W (BW),
    .T_RST (P_RST), .T_CKE (P_CKE), .T_XPR (P_XPR), .T_MRD (P_MRD),
    .T_MOD (P_MOD), .T_DLLK (P_DLLK), .T_ZQI (P_ZQI)
  ) uut (
    .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .odt_req (odt_req),
    .mr0_val (mr0_val), .mr1_val (mr1_val), .mr2_val (mr2_val), .mr3_val (mr3_val),
    .ddr_reset_n (ddr_reset_n), .ddr_cke (ddr_cke), .ddr_odt (ddr_odt),
    .ddr_cs_n (ddr_cs_n), .ddr_ras_n (ddr_ras_n), .ddr_cas_n (ddr_cas_n),
    .ddr_we_n (ddr_we_n), .ddr_ba (ddr_ba), .ddr_addr (ddr_addr),
    .init_done (init_done)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // edge bookkeeping: mark the last edge with reset or supply low
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n || !supply_ok) s_mark = cyc;
    odt_s = odt_req;
  end

  // golden model, compared at every falling edge
  int            t;
  logic [3:0]    e_cmd;
  logic [BW-1:0] e_ba;
  logic [AW-1:0] e_addr;
  string         ctag;
  always @(negedge clk) begin
    if (cyc > 0) begin
      t      = cyc - s_mark;
      e_ba   = '0;
      e_addr = '0;
      ctag   = "R7";
      if (t < E_CKE)      e_cmd = 4'b1111;
      else if (t == E_MR2) begin e_cmd = 4'b0000; e_ba = 3'd2; e_addr = mr2_val; ctag = "R4"; end
      else if (t == E_MR3) begin e_cmd = 4'b0000; e_ba = 3'd3; e_addr = mr3_val; ctag = "R4"; end
      else if (t == E_MR1) begin e_cmd = 4'b0000; e_ba = 3'd1; e_addr = mr1_val; ctag = "R4"; end
      else if (t == E_MR0) begin e_cmd = 4'b0000; e_ba = 3'd0; e_addr = mr0_val; ctag = "R4"; end
      else if (t == E_ZQ)  begin e_cmd = 4'b0110; e_addr = AW'(1) << 10; ctag = "R5"; end
      else                e_cmd = 4'b0111;
      chk((t == 0) ? "R1" : "R2", "ddr_reset_n", ddr_reset_n, (t >= P_RST));
      chk((t == 0) ? "R1" : "R3", "ddr_cke", ddr_cke, (t >= E_CKE));
      chk(ctag, "cmd{cs,ras,cas,we}", {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, e_cmd);
      chk(ctag, "ddr_ba", ddr_ba, e_ba);
      chk(ctag, "ddr_addr", ddr_addr, e_addr);
      chk((t == 0) ? "R1" : "R6", "init_done", init_done, (t >= E_DON));
      chk("R8", "ddr_odt", ddr_odt, (t >= E_DON) && odt_s);
    end
  end

  // termination request pattern
  initial begin
    odt_req = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      odt_req = ((cyc / 3) % 2) == 1;
    end
  end

  initial begin
    rst_n     = 1'b0;
    supply_ok = 1'b0;
    mr0_val = '0; mr1_val = '0; mr2_val = '0; mr3_val = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    // supply drop swept across every offset, then full completions
    for (int k = 1; k <= E_DON + 8; k++) begin
      supply_ok = 1'b0;
      mr0_val = AW'(k * 113 + 5);
      mr1_val = AW'(k * 271 + 9);
      mr2_val = AW'(k * 389 + 3);
      mr3_val = AW'(k * 97 + 17);
      wait_cyc(2);
      supply_ok = 1'b1;
      wait_cyc(k);
    end
    // R1: asynchronous reset in mid sequence
    supply_ok = 1'b0;
    wait_cyc(2);
    supply_ok = 1'b1;
    wait_cyc(30);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(E_DON + 10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule